// File: doc/BRIEF.md
# Multiplexed Local Bus Cycle Controller

This block runs read and write transfers for a 16-bit processor core on a local bus where the low address bits and the data share one set of pins. The core offers a request: a 20-bit address, a memory or I/O space flag, a direction flag and the write data. The controller then steps through four bus states:

- **T1** drives the address and pulses the address latch enable.
- **T2** asserts the read or write strobe.
- **T3** repeats for as long as the ready input is sampled low.
- **T4** releases the strobe and hands read data back to the core with a one-clock completion pulse.

The controller also drives the controls for an external bus transceiver: a data-enable and a direction line. They are ordered so that the transceiver never drives against the bus. Between transfers the controller honours a hold request from another bus master. It acknowledges the request and takes its outputs off the bus until the hold request is withdrawn.

The shared pins are modelled as an input half (`ad_in`) and an output half (`ad_out`), with the output enable `ad_oe` selecting which half is active.

Top module: `lbus_cycle_ctrl`

## Requirements
- R1: After reset the block is idle: `ale` low, `rd_n`, `wr_n` and `den_n` high, `dt_r` high, `status` 000, `ad_oe` low, `hlda` low, `ctl_oe` high, and `req_ready` high while `hold` is low.
- R2: A request accepted on a clock edge where `req_valid` and `req_ready` are both high starts T1 in the next clock. With ready high at the first T3 sample, the transfer lasts exactly four clocks. `ale` is high only in the first of them and `done` is high only in the fourth.
- R3: Each clock edge that ends a T3 state with `rdy` low adds one more T3 clock, so a transfer with N such samples lasts 4+N clocks.
- R4: In T1 `ad_out` carries address bits 15:0 and `ad_oe` is high. From T1 to T4, `a_hi` carries address bits 19:16 for memory transfers and 0000 for I/O transfers.
- R5: `rd_n` (reads) or `wr_n` (writes) is low from T2 through the last T3 and high otherwise. The two strobes are never low together.
- R6: On writes `ad_oe` stays high from T2 to T4 with `ad_out` equal to the write data. On reads `ad_oe` is low from T2 to T4.
- R7: On reads, `ad_in` is captured on the clock edge that ends the last T3. It is presented on `rd_data` during the clock where `done` is high.
- R8: `status` holds the transfer type from T1 through the last T3 and is 000 (passive) otherwise. The encoding is {I/O flag, write flag, not write flag}: 001 memory read, 010 memory write, 101 I/O read, 110 I/O write.
- R9: `dt_r` is low (receive) from T1 to T4 of a read and high at all other times. `den_n` is low from T2 through the last T3. `dt_r` never changes in a clock that follows one where `den_n` was low, and `den_n` never falls in a clock where `dt_r` changes.
- R10: `hold` is sampled only in the idle state. A hold raised mid-transfer is granted only after T4 and one idle clock. While `hlda` is high, `ctl_oe`, `ad_oe` and `ale` are low, `req_ready` is low, and no request is started.
- R11: After `hold` is seen low, `hlda` drops in the next clock with outputs still released. `ctl_oe` returns high one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core has a transfer request |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 20 | Transfer address |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-clock completion pulse (T4) |
| rd_data | output | 16 | Read data, valid with done on reads |
| ad_in | input | 16 | Shared address/data pins, input side |
| ad_out | output | 16 | Shared address/data pins, output side |
| ad_oe | output | 1 | Output enable for ad_out |
| a_hi | output | 4 | Upper address bits 19:16 |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver data enable, active low |
| dt_r | output | 1 | Transceiver direction, 1 transmit / 0 receive |
| status | output | 3 | Transfer type code |
| ctl_oe | output | 1 | Output enable for control and address lines |
| rdy | input | 1 | Ready, low inserts wait states |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus grant to the other master |

## Verification
Transfers are tried in four patterns, each checked clock by clock:

- Reads and writes in both spaces with no wait states. These separate the strobe, status and address encodings from one another.
- Wait counts from one to seven. These show whether each low ready sample adds exactly one clock.
- Read data that is correct only in the final T3 clock. This shows whether the capture edge is exactly the one that ends the last T3.
- Hold raised mid-transfer and hold raised while a request is pending. These show whether arbitration waits for the transfer to end, and whether the outputs come back one clock after the grant is withdrawn.

// File: rtl/lbus_pkg.sv
// Shared types for the multiplexed local bus controller: the cycle
// state encoding and the status code helper. Assumes nothing else.
package lbus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_T4   = 3'd4,
        ST_HOLD = 3'd5,
        ST_REL  = 3'd6
    } bus_st_e;

    localparam logic [2:0] STS_PASSIVE = 3'b000;

    // Status code of an active transfer: {io, write, not write}.
    function automatic logic [2:0] cycle_status(input logic io, input logic wr);
        return {io, wr, ~wr};
    endfunction

endpackage

// File: rtl/lbus_seq.sv
// Cycle sequencer: steps IDLE -> T1 -> T2 -> T3 (repeats while ready is
// low) -> T4, and handles the hold handshake between transfers.
// Assumes: hold and rdy are already synchronous to clk.
module lbus_seq
    import lbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_valid,
    input  logic    rdy,
    input  logic    hold,
    output bus_st_e state,
    output logic    req_ready,
    output logic    rd_take
);

    bus_st_e nxt;

    // Next-state choice; hold is looked at only in the idle state.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (hold)           nxt = ST_HOLD;
                else if (req_valid) nxt = ST_T1;
            end
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3:   if (rdy) nxt = ST_T4;
            ST_T4:   nxt = ST_IDLE;
            ST_HOLD: if (!hold) nxt = ST_REL;
            ST_REL:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Accept a request only in idle with no hold pending.
    always_comb req_ready = (state == ST_IDLE) && !hold;

    // Read data is taken on the edge that closes the last T3.
    always_comb rd_take = (state == ST_T3) && rdy;

endmodule

// File: rtl/lbus_dpath.sv
// Transfer datapath: registers the accepted request, multiplexes the
// address and write data onto the shared pins, and captures read data.
// Assumes: ADDR_W > DATA_W (upper bits leave on separate pins).
module lbus_dpath
    import lbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_st_e           state,
    input  logic              take_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_io,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              rd_take,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic              cur_io,
    output logic              cur_wr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              in_cyc;

    // Hold the request fields for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            cur_io  <= 1'b0;
            cur_wr  <= 1'b0;
        end else if (take_req) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            cur_io  <= req_io;
            cur_wr  <= req_write;
        end
    end

    // Capture read data at the end of the last T3.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data <= '0;
        else if (rd_take) rd_data <= ad_in;
    end

    // Flag the states T1..T4 of an active transfer.
    always_comb in_cyc = (state == ST_T1) || (state == ST_T2) ||
                         (state == ST_T3) || (state == ST_T4);

    // Shared pins: address in T1, write data afterwards.
    always_comb begin
        if (state == ST_T1)        ad_out = addr_q[DATA_W-1:0];
        else if (in_cyc && cur_wr) ad_out = wdata_q;
        else                       ad_out = '0;
    end

    // Upper address: driven for memory transfers, zero for I/O space.
    always_comb begin
        if (in_cyc && !cur_io) a_hi = addr_q[ADDR_W-1:DATA_W];
        else                   a_hi = {HI_W{1'b0}};
    end

endmodule

// File: rtl/lbus_ctl.sv
// Control decode: strobes, latch enable, transceiver controls, status
// code and output enables, all decoded from the registered state.
// Assumes: the state register is the only sequential input.
module lbus_ctl
    import lbus_pkg::*;
(
    input  bus_st_e    state,
    input  logic       cur_io,
    input  logic       cur_wr,
    output logic       ale,
    output logic       rd_n,
    output logic       wr_n,
    output logic       den_n,
    output logic       dt_r,
    output logic [2:0] status,
    output logic       ad_oe,
    output logic       ctl_oe,
    output logic       hlda,
    output logic       done
);

    logic in_cyc;
    logic strobe_ph;

    // Phase flags for the transfer and for the strobe window.
    always_comb begin
        in_cyc    = (state == ST_T1) || (state == ST_T2) ||
                    (state == ST_T3) || (state == ST_T4);
        strobe_ph = (state == ST_T2) || (state == ST_T3);
    end

    // Strobes and latch enable.
    always_comb begin
        ale  = (state == ST_T1);
        rd_n = !(strobe_ph && !cur_wr);
        wr_n = !(strobe_ph && cur_wr);
        done = (state == ST_T4);
    end

    // Transceiver: direction for the whole transfer, enable inside it.
    always_comb begin
        dt_r  = !(in_cyc && !cur_wr);
        den_n = !strobe_ph;
    end

    // Status code through the last T3, passive otherwise.
    always_comb status = (in_cyc && state != ST_T4) ? cycle_status(cur_io, cur_wr)
                                                     : STS_PASSIVE;

    // Output enables and grant.
    always_comb begin
        ad_oe  = (state == ST_T1) || (in_cyc && cur_wr);
        hlda   = (state == ST_HOLD);
        ctl_oe = (state != ST_HOLD) && (state != ST_REL);
    end

endmodule

// File: rtl/lbus_cycle_ctrl.sv
// Top of the multiplexed local bus controller: ties the sequencer, the
// datapath and the control decode together.
// Assumes: one request in flight; the core holds req_valid until accepted.
module lbus_cycle_ctrl
    import lbus_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_io,
    input  logic                     req_write,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     done,
    output logic [DATA_W-1:0]        rd_data,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     den_n,
    output logic                     dt_r,
    output logic [2:0]               status,
    output logic                     ctl_oe,
    input  logic                     rdy,
    input  logic                     hold,
    output logic                     hlda
);

    bus_st_e state;
    logic    rd_take;
    logic    cur_io;
    logic    cur_wr;
    logic    take_req;

    // A request is taken when both sides of the handshake agree.
    always_comb take_req = req_valid && req_ready;

    lbus_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .rdy       (rdy),
        .hold      (hold),
        .state     (state),
        .req_ready (req_ready),
        .rd_take   (rd_take)
    );

    lbus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .take_req  (take_req),
        .req_addr  (req_addr),
        .req_io    (req_io),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .rd_take   (rd_take),
        .ad_in     (ad_in),
        .ad_out    (ad_out),
        .a_hi      (a_hi),
        .cur_io    (cur_io),
        .cur_wr    (cur_wr),
        .rd_data   (rd_data)
    );

    lbus_ctl u_ctl (
        .state  (state),
        .cur_io (cur_io),
        .cur_wr (cur_wr),
        .ale    (ale),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .den_n  (den_n),
        .dt_r   (dt_r),
        .status (status),
        .ad_oe  (ad_oe),
        .ctl_oe (ctl_oe),
        .hlda   (hlda),
        .done   (done)
    );

endmodule

// File: rtl/lbus_cycle_chk.sv
// Protocol checker bound to the bus controller top. Watches only the
// block's ports.
module lbus_cycle_chk #(
    parameter int HI_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ale,
    input logic            rd_n,
    input logic            wr_n,
    input logic            den_n,
    input logic            dt_r,
    input logic [2:0]      status,
    input logic [HI_W-1:0] a_hi,
    input logic            ad_oe,
    input logic            ctl_oe,
    input logic            done,
    input logic            rdy,
    input logic            hold,
    input logic            hlda
);

    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_strobe_after_ale_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!rd_n || !wr_n));

    assert_done_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rdy));

    assert_io_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && status[2]) |-> (a_hi == '0));

    assert_dir_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dt_r) |-> $past(den_n));

    assert_den_after_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(den_n) |-> $stable(dt_r));

    assert_grant_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ctl_oe && !ad_oe && !ale));

    assert_grant_requested_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hlda) |-> $past(hold));

    assert_redrive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hlda) |=> ctl_oe);

endmodule

bind lbus_cycle_ctrl lbus_cycle_chk #(.HI_W(ADDR_W - DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .den_n  (den_n),
    .dt_r   (dt_r),
    .status (status),
    .a_hi   (a_hi),
    .ad_oe  (ad_oe),
    .ctl_oe (ctl_oe),
    .done   (done),
    .rdy    (rdy),
    .hold   (hold),
    .hlda   (hlda)
);

// File: tb/lbus_cycle_ctrl_bench.sv
module lbus_cycle_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [19:0] req_addr = '0;
    logic        req_io = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rd_data;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [3:0]  a_hi;
    logic        ale, rd_n, wr_n, den_n, dt_r;
    logic [2:0]  status;
    logic        ctl_oe;
    logic        rdy = 1'b1;
    logic        hold = 1'b0;
    logic        hlda;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    lbus_cycle_ctrl u_lbus_cycle_ctrl (.*);

    // Returns the data an external device gives back for an address.
    function automatic logic [15:0] dev_val(input logic [19:0] a);
        return a[15:0] ^ 16'hA5C3 ^ {a[19:16], 12'h000};
    endfunction

    // Returns the expected status code for a transfer type (R8).
    function automatic logic [2:0] exp_status(input logic io, input logic wr);
        return {io, wr, ~wr};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One transfer, checked clock by clock; optionally raises hold in T2.
    task automatic run_cycle(input logic [19:0] a, input logic io, input logic wr,
                             input logic [15:0] wd, input int nw, input bit hmid);
        logic [15:0] expd;
        int c;
        expd = dev_val(a);
        chk(req_ready == 1'b1, "R2 ready in idle", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_io = io; req_write = wr; req_wdata = wd;
        rdy = 1'b0; ad_in = ~expd;
        c = 0;
        while (c < 4 + nw && c < 40) begin
            @(negedge clk);
            c++;
            req_valid = 1'b0;
            chk(ale == (c == 1), "R2 ale", ale, c == 1);
            chk(rd_n == !(!wr && c >= 2 && c <= 3 + nw), "R5 rd_n", rd_n, !(!wr && c >= 2 && c <= 3 + nw));
            chk(wr_n == !(wr && c >= 2 && c <= 3 + nw), "R5 wr_n", wr_n, !(wr && c >= 2 && c <= 3 + nw));
            chk(den_n == !(c >= 2 && c <= 3 + nw), "R9 den_n", den_n, !(c >= 2 && c <= 3 + nw));
            chk(dt_r == wr, "R9 dt_r", dt_r, wr);
            chk(ad_oe == (c == 1 || wr), "R6 ad_oe", ad_oe, (c == 1 || wr));
            if (c == 1) chk(ad_out == a[15:0], "R4 address low", ad_out, a[15:0]);
            if (c >= 2 && wr) chk(ad_out == wd, "R6 write data", ad_out, wd);
            chk(a_hi == (io ? 4'h0 : a[19:16]), "R4 a_hi", a_hi, io ? 4'h0 : a[19:16]);
            chk(status == ((c <= 3 + nw) ? exp_status(io, wr) : 3'b000), "R8 status",
                status, (c <= 3 + nw) ? exp_status(io, wr) : 3'b000);
            chk(done == (c == 4 + nw), "R3 done timing", done, c == 4 + nw);
            if (done && !wr) chk(rd_data == expd, "R7 read data", rd_data, expd);
            chk(hlda == 1'b0, "R10 no grant mid-transfer", hlda, 0);
            rdy = (c >= 3 + nw);
            ad_in = (c == 3 + nw) ? expd : ~expd;
            if (hmid && c == 2) hold = 1'b1;
        end
        @(negedge clk);
        rdy = 1'b1;
        chk(dt_r == 1'b1 && rd_n && wr_n && !ale, "R9 idle after transfer", dt_r, 1);
        if (hmid) begin
            chk(hlda == 1'b0 && req_ready == 1'b0, "R10 hold waits one idle clock", hlda, 0);
            @(negedge clk);
            chk(hlda == 1'b1 && ctl_oe == 1'b0 && ad_oe == 1'b0, "R10 grant after transfer", hlda, 1);
        end
    endtask

    // Drops hold and checks the two-step return to driving the bus (R11).
    task automatic release_hold();
        hold = 1'b0;
        @(negedge clk);
        chk(hlda == 1'b0 && ctl_oe == 1'b0, "R11 grant drops, outputs still off", ctl_oe, 0);
        @(negedge clk);
        chk(ctl_oe == 1'b1 && req_ready == 1'b1, "R11 outputs driven again", ctl_oe, 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ale && rd_n && wr_n && den_n && dt_r && status == 3'b000 && !ad_oe && !hlda
            && ctl_oe && req_ready, "R1 reset state", {ale, rd_n, wr_n, den_n, dt_r, ad_oe, hlda, ctl_oe}, 8'b01111001);

        // Directed: all four transfer types, zero waits (R2).
        run_cycle(20'hABCDE, 1'b0, 1'b0, 16'h0000, 0, 0);
        run_cycle(20'h5A5A5, 1'b0, 1'b1, 16'hBEEF, 0, 0);
        run_cycle(20'hF1234, 1'b1, 1'b0, 16'h0000, 0, 0);
        run_cycle(20'h8FFFF, 1'b1, 1'b1, 16'h1357, 0, 0);
        // Directed: several wait states (R3).
        run_cycle(20'h12345, 1'b0, 1'b0, 16'h0000, 3, 0);
        run_cycle(20'hFEDCB, 1'b0, 1'b1, 16'hC0DE, 7, 0);
        // Directed: hold raised mid-transfer is deferred (R10, R11).
        run_cycle(20'h00F0F, 1'b0, 1'b0, 16'h0000, 2, 1);
        release_hold();

        // Directed: hold raised while a request is pending (R10).
        hold = 1'b1; req_valid = 1'b1; req_addr = 20'h33333; req_write = 1'b0; req_io = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(hlda == 1'b1 && ale == 1'b0 && req_ready == 1'b0, "R10 request blocked in hold", ale, 0);
        end
        req_valid = 1'b0;
        release_hold();

        // Random transfers mixed with hold.
        for (int k = 0; k < 40; k++) begin
            logic [19:0] ra;
            logic [15:0] rw;
            ra = 20'($urandom);
            rw = 16'($urandom);
            run_cycle(ra, 1'($urandom), 1'($urandom), rw, int'($urandom_range(0, 5)),
                      ($urandom_range(0, 4) == 0));
            if (hold) release_hold();
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule